// File: doc/BRIEF.md
# Latched Serial-In Parallel-Out Register

This block turns a serial bit stream into a parallel word while keeping that word stable. Bits arrive one per shift strobe and move along a chain of shift flops. A separate latch strobe copies the whole chain into an output register in a single cycle. The outputs therefore change only when a complete new word has been committed. An active-low output enable releases the parallel outputs to high impedance without losing the stored word.

The last flop of the shift chain is brought out as a cascade output. Several instances can share the strobes and form one long chain, with each cascade output feeding the serial input of the next instance. Both strobes are single-cycle enables in one system clock domain, and reset is asynchronous and active low.

Top module: `sipo_latched_reg`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, the shift chain and the output register hold all zeros, so the parallel outputs (enabled) and the cascade output read 0.
- R2: On a cycle with the shift strobe high, bit 0 of the shift chain takes the serial input, and each bit i (i > 0) takes the previous value of bit i-1.
- R3: The cascade output always equals the top bit (bit WIDTH-1) of the shift chain, so a bit appears there after WIDTH shift strobes.
- R4: The parallel outputs keep their value on every cycle without the latch strobe, whatever happens on the shift strobe and the serial input.
- R5: On a cycle with the latch strobe high, the output register takes the whole shift chain at once. After WIDTH shifts, the first bit sent sits on output bit WIDTH-1 and the last bit sent sits on bit 0.
- R6: When both strobes are high in the same cycle, the output register captures the chain as it was before that cycle's shift, and the shift still takes place.
- R7: With the output enable high, every parallel output is released (high impedance). Data latched earlier is still present when the enable goes low again.
- R8: On a cycle with neither strobe high, the shift chain and the output register keep their values.
- R9: Two instances chained through the cascade output, with shared strobes, act as one 2*WIDTH-bit register: after 2*WIDTH shifts and one latch, the downstream instance shows the first WIDTH bits sent and the upstream instance shows the last WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data bit, sampled when the shift strobe is high |
| shift_stb | input | 1 | Shift strobe: advance the chain by one position |
| latch_stb | input | 1 | Latch strobe: copy the chain into the output register |
| oe_n | input | 1 | Output enable, active low; high releases the parallel outputs |
| par_out | output | WIDTH | Parallel outputs of the output register, or high impedance |
| cascade_out | output | 1 | Top bit of the shift chain, for chaining instances |

## Verification
The clocked checks assume that the strobes and the serial input are settled before each rising clock edge. They also assume that the reset release is synchronous to the clock, so that the first checked cycle compares against reset values. The bench changes every input only on the falling clock edge and releases reset there as well, which keeps all activity half a period away from the sampling edge. The strobe and serial-input checks make no assumption about how strobes are combined. The stimulus therefore includes back-to-back shifts, latch-only cycles, idle cycles and cycles with both strobes high.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  // Combined view of the two strobes in one cycle.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_SHIFT = 2'b01,
    OP_LATCH = 2'b10,
    OP_BOTH  = 2'b11
  } strobe_op_e;

  function automatic strobe_op_e decode_op(input logic shift_s, input logic latch_s);
    return strobe_op_e'({latch_s, shift_s});
  endfunction

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] chain_q,
  output logic             chain_top
);

  localparam int TOP = WIDTH - 1;

  // Next chain value: new bit enters at bit 0, the rest move up one place.
  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] cur, input logic din);
    logic [WIDTH-1:0] nxt;
    nxt[0] = din;
    for (int i = 1; i < WIDTH; i++) nxt[i] = cur[i-1];
    return nxt;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else if (shift_en) chain_q <= advance(chain_q, ser_in);
  end

  assign chain_top = chain_q[TOP];

  // R2: the serial bit lands in bit 0
  a_r2_entry_bit: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> chain_q[0] == $past(ser_in));

  // R2: the other bits move up by one
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> chain_q[TOP:1] == $past(chain_q[TOP-1:0]));

  // R3: the cascade bit follows the bit just below the top
  a_r3_cascade_follow: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> chain_top == $past(chain_q[TOP-1]));

  // R8: no shift strobe, the chain is unchanged
  a_r8_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chain_q));

endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_en,
  input  logic [WIDTH-1:0] chain_d,
  output logic [WIDTH-1:0] store_q
);

  // Selects the value the output register takes on the next edge.
  function automatic logic [WIDTH-1:0] pick(input logic en, input logic [WIDTH-1:0] cur,
                                            input logic [WIDTH-1:0] fresh);
    return en ? fresh : cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= pick(latch_en, store_q, chain_d);
  end

  // R5, R6: a latch copies the chain as it stood before the edge
  a_r5_copy_chain: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> store_q == $past(chain_d));

  // R4: no latch strobe, the outputs hold
  a_r4_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(store_q));

endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
  parameter int WIDTH = 8
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] store_q,
  output logic [WIDTH-1:0] par_out
);

  assign par_out = oe_n ? {WIDTH{1'bz}} : store_q;

endmodule

// File: rtl/sipo_latched_reg.sv
module sipo_latched_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_stb,
  input  logic             latch_stb,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_out,
  output logic             cascade_out
);

  import sipo_pkg::*;

  strobe_op_e       op;
  logic             shift_fire;
  logic             latch_fire;
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] store_q;

  assign op         = decode_op(shift_stb, latch_stb);
  assign shift_fire = (op == OP_SHIFT) || (op == OP_BOTH);
  assign latch_fire = (op == OP_LATCH) || (op == OP_BOTH);

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_fire),
    .ser_in    (ser_in),
    .chain_q   (chain_q),
    .chain_top (cascade_out)
  );

  sipo_store_reg #(.WIDTH(WIDTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_en (latch_fire),
    .chain_d  (chain_q),
    .store_q  (store_q)
  );

  sipo_out_gate #(.WIDTH(WIDTH)) u_gate (
    .oe_n    (oe_n),
    .store_q (store_q),
    .par_out (par_out)
  );

  // R6: with both strobes, the store gets the pre-shift chain while the chain still moves
  a_r6_both_order: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && latch_stb) |=> (store_q == $past(chain_q)) && (chain_q[0] == $past(ser_in)));

  // R1: during reset both stages read zero
  always_comb begin
    if (!rst_n) a_r1_reset_zero: assert (chain_q == '0 && store_q == '0);
  end

endmodule

// File: tb/sipo_latched_reg_bench.sv
`timescale 1ns/1ps
module sipo_latched_reg_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_in = 1'b0, shift_stb = 1'b0, latch_stb = 1'b0, oe_n = 1'b0;
  logic [W-1:0] par_head, par_tail;
  logic         casc_head, casc_tail;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of both chained instances
  logic [W-1:0] m_chain = '0, m_store = '0, t_chain = '0, t_store = '0;

  always #2 clk = ~clk;

  sipo_latched_reg #(.WIDTH(W)) u_sipo_latched_reg (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_stb(shift_stb),
    .latch_stb(latch_stb), .oe_n(oe_n), .par_out(par_head), .cascade_out(casc_head));

  sipo_latched_reg #(.WIDTH(W)) u_tail (
    .clk(clk), .rst_n(rst_n), .ser_in(casc_head), .shift_stb(shift_stb),
    .latch_stb(latch_stb), .oe_n(oe_n), .par_out(par_tail), .cascade_out(casc_tail));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_released(input string req, input logic [W-1:0] act);
    checks++;
    if (!(act === {W{1'bz}} || act === '0)) begin
      errors++;
      $display("FAIL %s: actual %b expected released", req, act);
    end
  endtask

  // One cycle: drive at the falling edge, update the model, sample 1 ns after the rising edge.
  task automatic step(input logic s, input logic sh, input logic la, input logic oe, input string req);
    logic [W-1:0] nm, nt;
    @(negedge clk);
    ser_in = s; shift_stb = sh; latch_stb = la; oe_n = oe;
    nm = sh ? {m_chain[W-2:0], s} : m_chain;
    nt = sh ? {t_chain[W-2:0], m_chain[W-1]} : t_chain;
    if (la) begin m_store = m_chain; t_store = t_chain; end
    m_chain = nm; t_chain = nt;
    @(posedge clk); #1;
    check({req, " cascade"}, {{(W-1){1'b0}}, casc_head}, {{(W-1){1'b0}}, m_chain[W-1]});
    if (oe) begin
      check_released({req, " head released"}, par_head);
    end else begin
      check({req, " head par"}, par_head, m_store);
      check({req, " tail par"}, par_tail, t_store);
    end
  endtask

  task automatic send_word(input logic [W-1:0] w, input string req);
    for (int i = W - 1; i >= 0; i--) step(w[i], 1'b1, 1'b0, 1'b0, req);
  endtask

  // Vector table: {ser_in, shift, latch, oe_n}
  localparam int NV = 20;
  localparam logic [3:0] VEC [0:NV-1] = '{
    4'b1100, 4'b0100, 4'b1100, 4'b1100, 4'b0000, 4'b0100, 4'b1100, 4'b0100,
    4'b1010, 4'b0100, 4'b1100, 4'b0000, 4'b1110, 4'b0010, 4'b1101, 4'b0101,
    4'b1011, 4'b0000, 4'b1100, 4'b0010
  };

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero while in reset
    #1;
    check("R1 reset par", par_head, '0);
    check("R1 reset cascade", {{(W-1){1'b0}}, casc_head}, '0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, "R1 R8 idle after reset");

    // Table walk covers R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++)
      step(VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], "R2 R4 R5 table");

    // R5: a full word, first bit on the top output bit
    send_word(8'b1011_0010, "R4 shifting");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R5 latch");
    check("R5 word order", par_head, 8'b1011_0010);

    // R3: after W shifts the first bit reaches the cascade output
    send_word(8'b0111_1111, "R3 fill");
    check("R3 cascade first bit", {{(W-1){1'b0}}, casc_head}, '0);

    // R6: both strobes; the store takes the pre-shift chain
    step(1'b1, 1'b1, 1'b1, 1'b0, "R6 both");
    check("R6 pre-shift capture", par_head, 8'b0111_1111);
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6 post");
    check("R6 shift still done", par_head, 8'b1111_1111);

    // R7: released outputs, data kept
    send_word(8'b0101_1010, "R7 load");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R7 latch");
    step(1'b1, 1'b0, 1'b0, 1'b1, "R7 released");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R7 released");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7 enabled again");
    check("R7 data kept", par_head, 8'b0101_1010);

    // R8: idle cycles with a toggling serial input change nothing
    for (int k = 0; k < 4; k++) step(k[0], 1'b0, 1'b0, 1'b0, "R8 idle");
    check("R8 hold", par_head, 8'b0101_1010);

    // R9: 16-bit word through two chained instances
    send_word(8'hC3, "R9 first half");
    send_word(8'h5E, "R9 second half");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R9 latch");
    check("R9 tail shows first half", par_tail, 8'hC3);
    check("R9 head shows second half", par_head, 8'h5E);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule